// File: doc/BRIEF.md
# Deflection Safety and Blanking Controller

This block collects the protection and blanking conditions of a monitor deflection controller. From a set of digital flags it produces three registered outputs: the horizontal drive enable, the vertical drive enable and the composite blanking pin. The flags are supply-good, X-ray trip, duty-control-off (standby), horizontal flyback, vertical flyback, vertical sync, vertical sawtooth retrace, a frequency-change pulse, and a flag that marks the vertical flyback input as unused.

Every input is asynchronous. Each one passes through a synchronizer chain of `SYNC_STAGES` flops before any logic uses it. An X-ray trip sets a fault latch. Only a loss of supply clears that latch. Standby, by contrast, is never held. A four-bit cause vector reports each drive-inhibit source separately so that test equipment can see it.

Top module: `defl_guard`

## Requirements
- R1: After reset, and while the synchronized supply-good is low, both drive enables are 0, blanking is active, and cause bit 0 (supply low) is 1.
- R2: A change on any input shows on the outputs after SYNC_STAGES+1 rising clock edges. With the default of 2 stages this is the third edge.
- R3: The horizontal drive enable is 1 only when supply-good is 1, no X-ray fault is present, duty-control-off is 0 and horizontal flyback is 0.
- R4: An X-ray trip seen while supply-good is 1 sets a fault latch. The latch stays set after the trip input returns to 0, whatever the other inputs do.
- R5: The fault latch clears only while supply-good is 0. When supply-good is 0 and the trip input is 1 in the same cycle, clearing wins.
- R6: The vertical drive enable equals supply-good AND NOT duty-control-off. When duty-control-off is released, the drives recover with no memory of it.
- R7: Internal blanking is the OR of the following: frequency change, X-ray fault, supply low, duty-control-off, horizontal flyback, vertical sync, and a vertical term. The vertical term is vertical flyback when the unused flag is 0, and vertical sawtooth retrace when the unused flag is 1.
- R8: The blanking pin equals internal blanking when BLANK_LOW=0, and its inverse when BLANK_LOW=1.
- R9: The cause vector holds the following, each registered in step with the drive enables: bit 0 = supply low, bit 1 = X-ray fault, bit 2 = duty-control-off, bit 3 = horizontal flyback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply is above its working threshold |
| xray_trip | input | 1 | X-ray overvoltage comparator output |
| duty_off | input | 1 | Duty control pulled below the off threshold (standby) |
| h_flyback | input | 1 | Horizontal flyback pulse |
| v_flyback | input | 1 | Vertical flyback pulse |
| v_sync | input | 1 | Vertical sync, polarity-corrected |
| v_retrace | input | 1 | Vertical sawtooth discharge interval |
| freq_change | input | 1 | Pulse marking a scan frequency change |
| vfly_unused | input | 1 | Vertical flyback input not wired |
| h_drive_en | output | 1 | Horizontal drive permitted |
| v_drive_en | output | 1 | Vertical drive permitted |
| blank_pin | output | 1 | Composite blanking, polarity per BLANK_LOW |
| inhibit_cause | output | 4 | Registered inhibit sources (bit map in R9) |

## Verification
Two events can land in the same cycle: a loss of supply and an X-ray trip. The latch then sees a set request and a clear request at once. The bench provokes this by raising the trip while supply-good is low. It then restores supply with the trip low and expects the horizontal drive to return, which shows that clearing won. An exhaustive sweep over all 512 input combinations, with supply-good as the slowest-changing bit, also produces trip and standby edges on the same cycles as a latch that is already set. A bench model of the latch predicts every output there.

// File: rtl/defl_pkg.sv
package defl_pkg;
   localparam int NUM_IN = 9;
   // positions of the flags inside the synchronized vector
   localparam int IX_SUP   = 0;
   localparam int IX_XRAY  = 1;
   localparam int IX_DUTY  = 2;
   localparam int IX_HFLY  = 3;
   localparam int IX_VFLY  = 4;
   localparam int IX_VSYNC = 5;
   localparam int IX_VRET  = 6;
   localparam int IX_FCHG  = 7;
   localparam int IX_VFUN  = 8;

   typedef struct packed {
      logic hfly;
      logic duty;
      logic xray;
      logic sup_low;
   } cause_t;
endpackage

// File: rtl/defl_sync_bank.sv
module defl_sync_bank #(
   parameter int WIDTH  = 9,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("defl_sync_bank: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("defl_sync_bank: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain[LAST];
   end
endmodule

// File: rtl/defl_xray_latch.sv
module defl_xray_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_i,
   input  logic trip_i,
   output logic latch_q,
   output logic fault_o
);
   // fault as seen this cycle: clear dominates set
   assign fault_o = sup_i & (latch_q | trip_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= 1'b0;
      else        latch_q <= fault_o;
   end

   // R5
   latch_clear_only_on_supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_q) |-> !$past(sup_i));
   // R4
   latch_set_only_by_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q) |-> $past(trip_i));
endmodule

// File: rtl/defl_combine.sv
module defl_combine
   import defl_pkg::*;
#(
   parameter bit BLANK_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] s_i,
   input  logic              fault_i,
   output logic              h_en_o,
   output logic              v_en_o,
   output logic              blank_o,
   output cause_t            cause_o
);
   logic   sup, duty, hfly, vterm;
   logic   h_nx, v_nx, blk_nx, blank_q;
   cause_t cause_nx;

   assign sup  = s_i[IX_SUP];
   assign duty = s_i[IX_DUTY];
   assign hfly = s_i[IX_HFLY];
   assign vterm = s_i[IX_VFUN] ? s_i[IX_VRET] : s_i[IX_VFLY];

   always_comb begin
      h_nx   = sup & ~fault_i & ~duty & ~hfly;
      v_nx   = sup & ~duty;
      blk_nx = s_i[IX_FCHG] | fault_i | ~sup | duty | hfly | s_i[IX_VSYNC] | vterm;
      cause_nx.sup_low = ~sup;
      cause_nx.xray    = fault_i;
      cause_nx.duty    = duty;
      cause_nx.hfly    = hfly;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_en_o  <= 1'b0;
         v_en_o  <= 1'b0;
         blank_q <= 1'b1;
         cause_o <= '{hfly: 1'b0, duty: 1'b0, xray: 1'b0, sup_low: 1'b1};
      end else begin
         h_en_o  <= h_nx;
         v_en_o  <= v_nx;
         blank_q <= blk_nx;
         cause_o <= cause_nx;
      end
   end

   if (BLANK_LOW) begin : g_blank_low
      assign blank_o = ~blank_q;
   end else begin : g_blank_high
      assign blank_o = blank_q;
   end

   // R3
   h_needs_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_en_o |-> v_en_o);
   // R7
   v_off_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !v_en_o |-> blank_q);
   // R3
   fault_kills_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_o.xray |-> !h_en_o);
   // R1
   sup_low_kills_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_o.sup_low |-> (!v_en_o && blank_q));
endmodule

// File: rtl/defl_guard.sv
module defl_guard
   import defl_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit BLANK_LOW   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       xray_trip,
   input  logic       duty_off,
   input  logic       h_flyback,
   input  logic       v_flyback,
   input  logic       v_sync,
   input  logic       v_retrace,
   input  logic       freq_change,
   input  logic       vfly_unused,
   output logic       h_drive_en,
   output logic       v_drive_en,
   output logic       blank_pin,
   output logic [3:0] inhibit_cause
);
   logic [NUM_IN-1:0] raw, syn;
   logic              latch_q, fault;
   cause_t            cause;

   always_comb begin
      raw           = '0;
      raw[IX_SUP]   = supply_ok;
      raw[IX_XRAY]  = xray_trip;
      raw[IX_DUTY]  = duty_off;
      raw[IX_HFLY]  = h_flyback;
      raw[IX_VFLY]  = v_flyback;
      raw[IX_VSYNC] = v_sync;
      raw[IX_VRET]  = v_retrace;
      raw[IX_FCHG]  = freq_change;
      raw[IX_VFUN]  = vfly_unused;
   end

   defl_sync_bank #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn));

   defl_xray_latch i_latch (
      .clk(clk), .rst_n(rst_n), .sup_i(syn[IX_SUP]), .trip_i(syn[IX_XRAY]),
      .latch_q(latch_q), .fault_o(fault));

   defl_combine #(.BLANK_LOW(BLANK_LOW)) i_comb (
      .clk(clk), .rst_n(rst_n), .s_i(syn), .fault_i(fault),
      .h_en_o(h_drive_en), .v_en_o(v_drive_en), .blank_o(blank_pin),
      .cause_o(cause));

   assign inhibit_cause = cause;

   // R4
   latched_fault_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && syn[IX_SUP]) |=> inhibit_cause[1]);
endmodule

// File: tb/test_defl_guard.sv
module test_defl_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 0, xray_trip = 0, duty_off = 0, h_flyback = 0, v_flyback = 0;
   logic v_sync = 0, v_retrace = 0, freq_change = 0, vfly_unused = 0;
   logic h_drive_en, v_drive_en, blank_pin;
   logic [3:0] inhibit_cause;
   int checks = 0, fails = 0;
   bit done = 0;
   bit latch_m = 0;

   always #4 clk = ~clk;

   defl_guard i_defl_guard (.*);

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // hold inputs long enough for sync + output register, sample mid-low phase
   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic apply(input logic [8:0] v);
      xray_trip   = v[0];
      duty_off    = v[1];
      h_flyback   = v[2];
      v_flyback   = v[3];
      v_sync      = v[4];
      v_retrace   = v[5];
      freq_change = v[6];
      vfly_unused = v[7];
      supply_ok   = v[8];
      if (!v[8]) latch_m = 0;
      else if (v[0]) latch_m = 1;
   endtask

   task automatic check_all(input string tag);
      logic eh, ev, eb, vt;
      vt = vfly_unused ? v_retrace : v_flyback;
      eh = supply_ok & ~latch_m & ~duty_off & ~h_flyback;
      ev = supply_ok & ~duty_off;
      eb = freq_change | latch_m | ~supply_ok | duty_off | h_flyback | v_sync | vt;
      chk({tag, " R3 h_drive"}, {3'b0, h_drive_en}, {3'b0, eh});
      chk({tag, " R6 v_drive"}, {3'b0, v_drive_en}, {3'b0, ev});
      chk({tag, " R7 R8 blank"}, {3'b0, blank_pin}, {3'b0, eb});
      chk({tag, " R9 cause"}, inhibit_cause, {h_flyback, duty_off, latch_m, ~supply_ok});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 reset h", {3'b0, h_drive_en}, 4'h0);
      chk("R1 reset v", {3'b0, v_drive_en}, 4'h0);
      chk("R1 reset blank", {3'b0, blank_pin}, 4'h1);
      chk("R1 reset cause", inhibit_cause, 4'h1);
      rst_n = 1;

      // R2 latency: supply comes up, enables rise on third edge
      apply(9'h100);
      @(posedge clk); @(posedge clk); #1;
      chk("R2 not yet after 2 edges", {3'b0, h_drive_en}, 4'h0);
      @(posedge clk); #1;
      chk("R2 after 3 edges", {3'b0, h_drive_en}, 4'h1);
      settle();

      // R4 short trip pulse latches, persists after release
      apply(9'h101); @(negedge clk);
      apply(9'h100); settle();
      chk("R4 latch holds h off", {3'b0, h_drive_en}, 4'h0);
      chk("R4 latch holds blank", {3'b0, blank_pin}, 4'h1);
      // R6 standby pulse does not clear latch; v recovers after release
      apply(9'h102); settle();
      chk("R6 standby v off", {3'b0, v_drive_en}, 4'h0);
      apply(9'h100); settle();
      chk("R6 standby release v back", {3'b0, v_drive_en}, 4'h1);
      chk("R4 latch survives standby", {3'b0, h_drive_en}, 4'h0);
      // R5 supply loss clears
      apply(9'h000); settle();
      apply(9'h100); settle();
      chk("R5 cleared by supply loss", {3'b0, h_drive_en}, 4'h1);
      // R5 coincident supply low and trip: clear wins
      apply(9'h001); settle();
      chk("R5 coincident cause", inhibit_cause, 4'h1);
      apply(9'h100); settle();
      chk("R5 coincident h back", {3'b0, h_drive_en}, 4'h1);
      chk("R5 coincident blank off", {3'b0, blank_pin}, 4'h0);

      // exhaustive sweep, supply is the slowest bit
      for (int i = 0; i < 512; i++) begin
         apply(i[8:0]);
         settle();
         check_all($sformatf("sweep %0d", i));
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule